// File: doc/BRIEF.md
# USB device DMA master controller

This block drives the DMA side of an external USB device controller that acts as a DMA slave. Each programmed transfer moves a number of 16-bit words in one direction, between the device and one of two data targets: a small local buffer memory addressed from zero, or a direct first-in first-out path for bulk traffic. A processor programs the word count, the direction and the target, then issues a one-clock start pulse. It learns that the transfer has finished from a sticky done flag and a one-clock interrupt pulse.

Every word is paced by the device. A word cycle opens only while the device's request line is high and, on the direct path, only while the FIFO can accept or supply a word. The acknowledge line rises one clock ahead of an active-low read or write strobe. The strobe is held for three clocks, then acknowledge and strobe are both released for two recovery clocks. A word therefore takes six clocks, which is 75 ns at 80 MHz and meets the 80 ns per word budget. The end-of-transfer line is raised during the strobe of the last word.

Top module: `usb_dma_master`

## Requirements
- R1: After reset, dev_dack and dev_eot are 0, dev_rd_n and dev_wr_n are 1, and xfer_busy, xfer_done and xfer_irq are 0.
- R2: dev_dack rises only on a clock edge at which dev_dreq was sampled high. While dev_dreq stays low after a start, no word cycle begins.
- R3: In each word, dev_dack is high one clock before the strobe goes low. The strobe stays low for exactly 3 clocks with dev_dack high. Both are then released for at least 2 clocks. With the request and the target always ready, consecutive dev_dack rises are 6 clocks apart.
- R4: dev_eot is high only while a strobe is low, and only during the final word of a transfer. It is therefore high for exactly 3 clocks per transfer.
- R5: With cfg_to_dev=0 and cfg_direct=0, word i read from dev_din is written to buffer address i. The address restarts at 0 with each transfer.
- R6: With cfg_to_dev=1 and cfg_direct=0, word i sent on dev_dout is the buffer word at address i. The buffer returns buf_rdata one clock after buf_addr.
- R7: With cfg_to_dev=0 and cfg_direct=1, words read from the device are pushed to the FIFO in order, one push per word. No word cycle begins while fifo_full is high.
- R8: With cfg_to_dev=1 and cfg_direct=1, words are popped from a show-ahead FIFO in order and sent on dev_dout, one pop per word. No word cycle begins while fifo_empty is high.
- R9: The transfer moves exactly cfg_len words. When the last recovery ends, xfer_done is set and xfer_irq is high for exactly one clock. xfer_done stays set until the next accepted start, which clears it on the clock after the start.
- R10: A start with cfg_len=0 moves no word. It sets xfer_done and pulses xfer_irq on the clock after the start.
- R11: A start pulse while xfer_busy is high is ignored. The running transfer keeps its word count, direction and target.
- R12: Only dev_rd_n is driven low when reading from the device (cfg_to_dev=0), and only dev_wr_n when writing to it (cfg_to_dev=1). The two are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | One-clock start pulse, accepted when idle |
| cfg_len | input | CW (16) | Number of words to move |
| cfg_to_dev | input | 1 | 1: memory to device, 0: device to memory |
| cfg_direct | input | 1 | 1: FIFO path, 0: local buffer |
| xfer_busy | output | 1 | A transfer is running |
| xfer_done | output | 1 | Sticky completion flag |
| xfer_irq | output | 1 | One-clock completion pulse |
| dev_dreq | input | 1 | Device requests a word |
| dev_dack | output | 1 | Acknowledge to the device |
| dev_rd_n | output | 1 | Active-low read strobe |
| dev_wr_n | output | 1 | Active-low write strobe |
| dev_eot | output | 1 | End of transfer, final word |
| dev_din | input | DW (16) | Word from the device |
| dev_dout | output | DW (16) | Word to the device |
| buf_addr | output | AW (8) | Local buffer word address |
| buf_we | output | 1 | Local buffer write enable |
| buf_wdata | output | DW (16) | Local buffer write data |
| buf_rdata | input | DW (16) | Local buffer read data, one clock latency |
| fifo_full | input | 1 | Inbound FIFO cannot accept a word |
| fifo_push | output | 1 | Push one word into the inbound FIFO |
| fifo_wdata | output | DW (16) | Word pushed into the FIFO |
| fifo_empty | input | 1 | Outbound FIFO has no word |
| fifo_pop | output | 1 | Pop the head word of the outbound FIFO |
| fifo_rdata | input | DW (16) | Head word of the outbound FIFO |

## Verification
Every combination of direction and target is run twice. In one run the request and the FIFO flags are held ready, which pins the six-clock word period and the exact strobe and end-of-transfer windows. In the other, random request and FIFO-flag jitter stretch the gaps, which exposes any word begun without permission or any data slip under backpressure. Directed cases hold the request low, the FIFO full or the FIFO empty at the start to show that nothing moves. Further directed cases use a zero-length start, a start pulse issued mid-transfer, and back-to-back buffer transfers, which tell apart a pointer that restarts at zero from one that continues.

// File: rtl/usb_dma_pkg.sv
package usb_dma_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARM,
    PH_ACK,
    PH_STRB,
    PH_RECOV
  } dma_phase_t;

  // A word may start when the selected target can take or give one.
  function automatic logic target_ready(input logic direct, input logic to_dev,
                                        input logic full, input logic empty);
    if (!direct) return 1'b1;
    return to_dev ? !empty : !full;
  endfunction

  // Clocks from one acknowledge rise to the next with no stalls.
  function automatic int unsigned word_clocks(input int unsigned strb,
                                              input int unsigned recov);
    return 1 + strb + recov;
  endfunction

endpackage

// File: rtl/dma_phase_seq.sv
module dma_phase_seq
  import usb_dma_pkg::*;
#(
  parameter int unsigned STRB_CLKS  = 3,
  parameter int unsigned RECOV_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       go_ok,
  input  logic       more_words,
  output dma_phase_t phase,
  output logic       strobe_last,
  output logic       recov_last
);
  localparam int unsigned TMAX = (STRB_CLKS > RECOV_CLKS) ? STRB_CLKS : RECOV_CLKS;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  logic [TW-1:0] tmr;

  assign strobe_last = (phase == PH_STRB)  && (tmr == TW'(STRB_CLKS - 1));
  assign recov_last  = (phase == PH_RECOV) && (tmr == TW'(RECOV_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      tmr   <= '0;
    end else begin
      case (phase)
        PH_IDLE:  if (launch) phase <= PH_ARM;
        PH_ARM:   if (go_ok)  phase <= PH_ACK;
        PH_ACK: begin
          phase <= PH_STRB;
          tmr   <= '0;
        end
        PH_STRB: begin
          if (strobe_last) begin
            phase <= PH_RECOV;
            tmr   <= '0;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        PH_RECOV: begin
          if (recov_last) begin
            tmr <= '0;
            if (!more_words)  phase <= PH_IDLE;
            else if (go_ok)   phase <= PH_ACK;
            else              phase <= PH_ARM;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_word_count.sv
module dma_word_count #(
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          step,
  output logic [CW-1:0] remaining,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      addr      <= '0;
    end else if (load) begin
      remaining <= len;
      addr      <= '0;
    end else if (step) begin
      remaining <= remaining - CW'(1);
      addr      <= addr + AW'(1);
    end
  end
endmodule

// File: rtl/dma_data_route.sv
module dma_data_route #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_out,
  input  logic          word_end,
  input  logic          direct,
  input  logic [DW-1:0] buf_rdata,
  input  logic [DW-1:0] fifo_rdata,
  input  logic [DW-1:0] dev_din,
  output logic          buf_we,
  output logic          fifo_push,
  output logic          fifo_pop,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] dev_dout
);
  // Inbound words go straight to the chosen target on the strobe's last clock.
  assign buf_we    = word_end && !direct;
  assign fifo_push = word_end &&  direct;
  assign wdata     = dev_din;

  // Outbound words are fetched in the acknowledge clock and held through the strobe.
  assign fifo_pop  = load_out && direct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dev_dout <= '0;
    else if (load_out) dev_dout <= direct ? fifo_rdata : buf_rdata;
  end
endmodule

// File: rtl/usb_dma_master.sv
module usb_dma_master
  import usb_dma_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned CW         = 16,
  parameter int unsigned AW         = 8,
  parameter int unsigned STRB_CLKS  = 3,
  parameter int unsigned RECOV_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic [CW-1:0] cfg_len,
  input  logic          cfg_to_dev,
  input  logic          cfg_direct,
  output logic          xfer_busy,
  output logic          xfer_done,
  output logic          xfer_irq,
  input  logic          dev_dreq,
  output logic          dev_dack,
  output logic          dev_rd_n,
  output logic          dev_wr_n,
  output logic          dev_eot,
  input  logic [DW-1:0] dev_din,
  output logic [DW-1:0] dev_dout,
  output logic [AW-1:0] buf_addr,
  output logic          buf_we,
  output logic [DW-1:0] buf_wdata,
  input  logic [DW-1:0] buf_rdata,
  input  logic          fifo_full,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_wdata,
  input  logic          fifo_empty,
  output logic          fifo_pop,
  input  logic [DW-1:0] fifo_rdata
);
  dma_phase_t    phase;
  logic          idle, launch, finish_zero, finish_run;
  logic          strobe_last, recov_last, go_ok, more_words, last_word;
  logic          to_dev_q, direct_q, done_q, irq_q;
  logic          load_out, word_end;
  logic [CW-1:0] remaining;
  logic [DW-1:0] in_word;

  // Named events for the checker and the control logic.
  assign idle        = (phase == PH_IDLE);
  assign launch      = cfg_start && idle && (cfg_len != '0);
  assign finish_zero = cfg_start && idle && (cfg_len == '0);
  assign more_words  = (remaining != '0);
  assign last_word   = (remaining == CW'(1));
  assign finish_run  = recov_last && !more_words;
  assign go_ok       = dev_dreq && target_ready(direct_q, to_dev_q, fifo_full, fifo_empty);
  assign load_out    = (phase == PH_ACK) && to_dev_q;
  assign word_end    = strobe_last && !to_dev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_dev_q <= 1'b0;
      direct_q <= 1'b0;
    end else if (launch) begin
      to_dev_q <= cfg_to_dev;
      direct_q <= cfg_direct;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= finish_zero || finish_run;
      if (launch)                          done_q <= 1'b0;
      else if (finish_zero || finish_run)  done_q <= 1'b1;
    end
  end

  dma_phase_seq #(
    .STRB_CLKS (STRB_CLKS),
    .RECOV_CLKS(RECOV_CLKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .go_ok      (go_ok),
    .more_words (more_words),
    .phase      (phase),
    .strobe_last(strobe_last),
    .recov_last (recov_last)
  );

  dma_word_count #(
    .CW(CW),
    .AW(AW)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .len      (cfg_len),
    .step     (strobe_last),
    .remaining(remaining),
    .addr     (buf_addr)
  );

  dma_data_route #(
    .DW(DW)
  ) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_out  (load_out),
    .word_end  (word_end),
    .direct    (direct_q),
    .buf_rdata (buf_rdata),
    .fifo_rdata(fifo_rdata),
    .dev_din   (dev_din),
    .buf_we    (buf_we),
    .fifo_push (fifo_push),
    .fifo_pop  (fifo_pop),
    .wdata     (in_word),
    .dev_dout  (dev_dout)
  );

  assign buf_wdata  = in_word;
  assign fifo_wdata = in_word;

  assign dev_dack  = (phase == PH_ACK) || (phase == PH_STRB);
  assign dev_rd_n  = !((phase == PH_STRB) && !to_dev_q);
  assign dev_wr_n  = !((phase == PH_STRB) &&  to_dev_q);
  assign dev_eot   = (phase == PH_STRB) && last_word;
  assign xfer_busy = !idle;
  assign xfer_done = done_q;
  assign xfer_irq  = irq_q;
endmodule

// File: rtl/usb_dma_checker.sv
module usb_dma_checker #(
  parameter int unsigned STRB_CLKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic dreq,
  input logic dack,
  input logic rd_n,
  input logic wr_n,
  input logic eot,
  input logic done,
  input logic irq,
  input logic fifo_full,
  input logic fifo_empty,
  input logic direct,
  input logic to_dev
);
  logic       strb;
  logic [7:0] run_q;

  assign strb = !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (strb) run_q <= run_q + 8'd1;
    else           run_q <= '0;
  end

  assert_dack_needs_dreq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack) |-> $past(dreq));

  assert_dack_leads_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb) |-> $past(dack));

  assert_strobe_inside_dack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> dack);

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb) |-> (run_q == 8'(STRB_CLKS)) && !dack);

  assert_eot_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> strb);

  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dack) && direct && !to_dev) |-> !$past(fifo_full));

  assert_empty_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dack) && direct && to_dev) |-> !$past(fifo_empty));

  assert_irq_one_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_read_strobe_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !to_dev);

  assert_write_strobe_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> to_dev);
endmodule

bind usb_dma_master usb_dma_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dreq      (dev_dreq),
  .dack      (dev_dack),
  .rd_n      (dev_rd_n),
  .wr_n      (dev_wr_n),
  .eot       (dev_eot),
  .done      (xfer_done),
  .irq       (xfer_irq),
  .fifo_full (fifo_full),
  .fifo_empty(fifo_empty),
  .direct    (direct_q),
  .to_dev    (to_dev_q)
);

// File: tb/usb_dma_master_bench.sv
`timescale 1ns/1ps
module usb_dma_master_bench;
  localparam int STRB  = 3;
  localparam int RECOV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0;
  logic [15:0] cfg_len = '0;
  logic        cfg_to_dev = 1'b0, cfg_direct = 1'b0;
  logic        xfer_busy, xfer_done, xfer_irq;
  logic        dev_dreq = 1'b0;
  logic        dev_dack, dev_rd_n, dev_wr_n, dev_eot;
  logic [15:0] dev_din, dev_dout;
  logic [7:0]  buf_addr;
  logic        buf_we;
  logic [15:0] buf_wdata, buf_rdata;
  logic        fifo_full = 1'b0, fifo_push, fifo_empty = 1'b0, fifo_pop;
  logic [15:0] fifo_wdata, fifo_rdata;

  always #10 clk = ~clk;

  usb_dma_master u_usb_dma_master (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_len(cfg_len),
    .cfg_to_dev(cfg_to_dev), .cfg_direct(cfg_direct), .xfer_busy(xfer_busy),
    .xfer_done(xfer_done), .xfer_irq(xfer_irq), .dev_dreq(dev_dreq),
    .dev_dack(dev_dack), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_eot(dev_eot), .dev_din(dev_din), .dev_dout(dev_dout),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .fifo_full(fifo_full), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .fifo_rdata(fifo_rdata)
  );

  // Models of the device, buffer and FIFOs
  logic [15:0] dev_src [256];
  logic [15:0] dev_sink [256];
  logic [15:0] bmem [256];
  logic [15:0] fo_src [256];
  logic [15:0] fi_mem [256];
  int rd_idx = 0, wr_idx = 0, fo_idx = 0, fi_cnt = 0;

  assign dev_din    = dev_src[rd_idx[7:0]];
  assign fifo_rdata = fo_src[fo_idx[7:0]];

  always @(posedge clk) begin
    if (buf_we) bmem[buf_addr] <= buf_wdata;
    buf_rdata <= bmem[buf_addr];
    if (fifo_push) begin
      fi_mem[fi_cnt[7:0]] <= fifo_wdata;
      fi_cnt <= fi_cnt + 1;
    end
    if (fifo_pop) fo_idx <= fo_idx + 1;
  end

  // Expected timing, restated from the requirements
  function automatic int exp_word_clocks();
    return 1 + STRB + RECOV;
  endfunction
  function automatic int exp_eot_clocks();
    return STRB;
  endfunction

  // Bus monitor, sampling at the falling edge
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  dack_rises, dreq_viol, gate_viol, gap_bad, strobe_bad, run;
  int  rd_runs, wr_runs, eot_cnt, eot_bad, irq_cnt, irq_double, last_rise;
  bit  have_rise, track_gap, cur_direct, cur_to_dev;
  logic dack_p = 0, dreq_p = 0, full_p = 0, empty_p = 0, strb_p = 0, rd_p = 0, irq_p = 0;
  logic [15:0] wr_hold;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dev_dack && !dack_p) begin
        dack_rises++;
        if (!dreq_p) dreq_viol++;
        if (cur_direct && !cur_to_dev && full_p) gate_viol++;
        if (cur_direct &&  cur_to_dev && empty_p) gate_viol++;
        if (have_rise && track_gap && (cyc - last_rise) != exp_word_clocks()) gap_bad++;
        have_rise = 1;
        last_rise = cyc;
      end
      if (!dev_rd_n || !dev_wr_n) begin
        run++;
        if (!dev_wr_n) wr_hold = dev_dout;
      end else if (strb_p) begin
        if (run != STRB) strobe_bad++;
        if (rd_p) begin rd_runs++; rd_idx++; end
        else begin wr_runs++; dev_sink[wr_idx[7:0]] = wr_hold; wr_idx++; end
        run = 0;
      end
      if (dev_eot) begin
        eot_cnt++;
        if (dev_rd_n && dev_wr_n) eot_bad++;
      end
      if (xfer_irq) begin
        irq_cnt++;
        if (irq_p) irq_double++;
      end
    end
    dack_p  = dev_dack;  dreq_p = dev_dreq; full_p = fifo_full; empty_p = fifo_empty;
    strb_p  = !dev_rd_n || !dev_wr_n; rd_p = !dev_rd_n; irq_p = xfer_irq;
  end

  int nchk = 0, nerr = 0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    dack_rises = 0; dreq_viol = 0; gate_viol = 0; gap_bad = 0; strobe_bad = 0; run = 0;
    rd_runs = 0; wr_runs = 0; eot_cnt = 0; eot_bad = 0; irq_cnt = 0; irq_double = 0;
    have_rise = 0;
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic run_xfer(input bit to_dev, input bit direct, input int len,
                          input bit jitter, input int hold, input bit poke);
    int bad;
    for (int i = 0; i < 256; i++) begin
      dev_src[i]  = 16'($urandom);
      fo_src[i]   = 16'($urandom);
      dev_sink[i] = 16'hFFFF;
      bmem[i]     = to_dev ? 16'($urandom) : (16'hDEAD ^ 16'(i));
    end
    rd_idx = 0; wr_idx = 0; fo_idx = 0; fi_cnt = 0;
    clear_stats();
    cur_direct = direct; cur_to_dev = to_dev; track_gap = !jitter;
    dev_dreq   = !(hold > 0 && !direct);
    fifo_full  = hold > 0 && direct && !to_dev;
    fifo_empty = hold > 0 && direct &&  to_dev;
    cfg_len = 16'(len); cfg_to_dev = to_dev; cfg_direct = direct; cfg_start = 1'b1;
    tick();
    cfg_start = 1'b0;
    check_eq("R9", "done cleared by start", int'(xfer_done), 0);
    check_eq("R9", "busy after start", int'(xfer_busy), 1);
    if (hold > 0) begin
      repeat (hold) tick();
      if (!direct)      check_eq("R2", "acks while dreq low", dack_rises, 0);
      else if (!to_dev) check_eq("R7", "acks while fifo full", dack_rises, 0);
      else              check_eq("R8", "acks while fifo empty", dack_rises, 0);
      dev_dreq = 1'b1; fifo_full = 1'b0; fifo_empty = 1'b0;
    end
    for (int t = 0; t < 4000 && irq_cnt == 0; t++) begin
      tick();
      if (jitter) begin
        dev_dreq   = ($urandom % 4) != 0;
        fifo_full  = direct && !to_dev && (($urandom % 3) == 0);
        fifo_empty = direct &&  to_dev && (($urandom % 3) == 0);
      end
      if (poke && t == 4) begin
        cfg_start = 1'b1; cfg_len = 16'd1; cfg_to_dev = !to_dev; cfg_direct = !direct;
      end else begin
        cfg_start = 1'b0;
      end
    end
    cfg_start = 1'b0;
    tick();
    tick();
    dev_dreq = 1'b0; fifo_full = 1'b0; fifo_empty = 1'b0;

    check_eq("R9", "words moved", dack_rises, len);
    check_eq("R9", "irq pulses", irq_cnt, 1);
    check_eq("R9", "irq longer than one clock", irq_double, 0);
    check_eq("R9", "done held", int'(xfer_done), 1);
    check_eq("R3", "strobe runs not 3 clocks", strobe_bad, 0);
    if (!jitter) check_eq("R3", "word period mismatches", gap_bad, 0);
    check_eq("R2", "ack without dreq", dreq_viol, 0);
    if (direct && !to_dev) check_eq("R7", "ack while fifo full", gate_viol, 0);
    if (direct &&  to_dev) check_eq("R8", "ack while fifo empty", gate_viol, 0);
    check_eq("R4", "eot clocks", eot_cnt, exp_eot_clocks());
    check_eq("R4", "eot outside strobe", eot_bad, 0);
    check_eq("R12", "strobes of wrong direction", to_dev ? rd_runs : wr_runs, 0);
    if (poke) check_eq("R11", "words after ignored restart", dack_rises, len);
    bad = 0;
    for (int i = 0; i < len; i++) begin
      if (!to_dev && !direct && bmem[i] != dev_src[i]) bad++;
      if ( to_dev && !direct && dev_sink[i] != bmem[i]) bad++;
      if (!to_dev &&  direct && fi_mem[i] != dev_src[i]) bad++;
      if ( to_dev &&  direct && dev_sink[i] != fo_src[i]) bad++;
    end
    if (!to_dev && !direct) check_eq("R5", "buffer words wrong", bad, 0);
    if ( to_dev && !direct) check_eq("R6", "device words wrong", bad, 0);
    if (!to_dev &&  direct) begin
      check_eq("R7", "fifo words wrong", bad, 0);
      check_eq("R7", "fifo pushes", fi_cnt, len);
    end
    if ( to_dev &&  direct) begin
      check_eq("R8", "device words wrong", bad, 0);
      check_eq("R8", "fifo pops", fo_idx, len);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      dev_src[i] = '0; dev_sink[i] = '0; bmem[i] = '0; fo_src[i] = '0; fi_mem[i] = '0;
    end
    clear_stats();
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    tick();
    // R1 reset state
    check_eq("R1", "dack", int'(dev_dack), 0);
    check_eq("R1", "rd_n", int'(dev_rd_n), 1);
    check_eq("R1", "wr_n", int'(dev_wr_n), 1);
    check_eq("R1", "eot", int'(dev_eot), 0);
    check_eq("R1", "done", int'(xfer_done), 0);
    check_eq("R1", "irq", int'(xfer_irq), 0);
    check_eq("R1", "busy", int'(xfer_busy), 0);

    // R10 zero-length start
    clear_stats();
    cfg_len = 16'd0; cfg_start = 1'b1;
    tick();
    cfg_start = 1'b0;
    check_eq("R10", "done after empty start", int'(xfer_done), 1);
    check_eq("R10", "irq after empty start", int'(xfer_irq), 1);
    tick();
    check_eq("R10", "irq second clock", int'(xfer_irq), 0);
    check_eq("R10", "busy", int'(xfer_busy), 0);
    check_eq("R10", "acks", dack_rises, 0);

    // Directed: steady ready, all four paths
    run_xfer(1'b0, 1'b0, 8, 1'b0, 0, 1'b0);
    run_xfer(1'b0, 1'b0, 5, 1'b0, 0, 1'b0);   // R5 pointer restarts at zero
    run_xfer(1'b1, 1'b0, 8, 1'b0, 0, 1'b0);
    run_xfer(1'b0, 1'b1, 8, 1'b0, 0, 1'b0);
    run_xfer(1'b1, 1'b1, 8, 1'b0, 0, 1'b0);
    // Directed: single word, long run
    run_xfer(1'b1, 1'b0, 1, 1'b0, 0, 1'b0);
    run_xfer(1'b0, 1'b0, 40, 1'b0, 0, 1'b0);
    // Directed holds: R2, R7, R8
    run_xfer(1'b0, 1'b0, 3, 1'b0, 20, 1'b0);
    run_xfer(1'b0, 1'b1, 3, 1'b0, 15, 1'b0);
    run_xfer(1'b1, 1'b1, 3, 1'b0, 15, 1'b0);
    // R11 start while busy
    run_xfer(1'b1, 1'b0, 5, 1'b0, 0, 1'b1);
    // Jittered versions of each path
    run_xfer(1'b0, 1'b0, 12, 1'b1, 0, 1'b0);
    run_xfer(1'b1, 1'b0, 12, 1'b1, 0, 1'b0);
    run_xfer(1'b0, 1'b1, 12, 1'b1, 0, 1'b0);
    run_xfer(1'b1, 1'b1, 12, 1'b1, 0, 1'b0);
    // Constrained random mix
    for (int k = 0; k < 18; k++) begin
      run_xfer(1'($urandom % 2), 1'($urandom % 2), 1 + int'($urandom % 24),
               1'($urandom % 2), 0, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule